// File: doc/BRIEF.md
# Overlapped scan test cycle sequencer

This block runs a register-level scan test on a circuit whose registers are stitched into one or more parallel scan chains. One chain word carries one bit per chain. After a start pulse the block shifts the first pattern in over a fixed number of clocks, called the scan length. It then gives the circuit one normal-mode clock, the capture, with every test pin low. From the second pattern on, it shifts the captured response out over the same clocks that shift the next pattern in. A final scan-length segment unloads the last response.

Pattern words and expected-response words arrive over two valid/ready feeds. Every word shifted out of the chains is compared with its expected word, and any mismatch sets a sticky fail flag. When one of the feeds it needs is not valid, the block freezes the chains with the hold pin instead of shifting. A chain-only mode skips the capture clocks. In that mode the block checks that each word leaving the chains equals the word it put in one scan length earlier, which checks the integrity of the chains themselves.

Top module: `scanseq_top`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `fail`, `scan_en`, `pat_ready` and `exp_ready` are 0, and `hold_en` is 1. While idle, `hold_en` stays 1 and no feed transfer happens.
- R2: The scan length L equals ceil(REGS / CHAINS), which is 3 for the defaults. The first segment shifts exactly L pattern words in, and during it `exp_ready` stays 0.
- R3: In capture mode (`chain_mode`=0), each pattern's scan-in segment is followed by exactly one clock in which `scan_en`=0 and `hold_en`=0. There are never two such clocks in a row, and `scan_en` and `hold_en` are never both 1.
- R4: For patterns 2..N, the scan-in of the pattern and the scan-out of the previous response share the same clocks. During the final unload segment, `chain_in` is all zeros.
- R5: Without stalls, a capture-mode run keeps `busy` high for exactly (N+1)·L + N clocks. It then drops `busy` and raises `done`, and `done` stays high until the next accepted start.
- R6: Each word shifted out after the first segment is compared bit for bit with the expected word taken in on the same clock. A mismatch sets `fail`, which stays set until the next accepted start clears it.
- R7: In chain-only mode (`chain_mode`=1) no capture clock occurs and `busy` lasts (N+1)·L clocks. The expected feed is unused. Each word out is compared with the word shifted in L shifts earlier, and a mismatch sets `fail`.
- R8: If a word that a shift needs is not valid, that clock has `scan_en`=0 and `hold_en`=1 and no word is taken from either feed. No pattern word is lost or repeated.
- R9: A start pulse while `busy` is high is ignored and does not change the length of the run.
- R10: A start with `pat_count`=0 performs no shift and raises `done` on the next clock.
- R11: `pat_ready` and `exp_ready` are only asserted on shift clocks, and only while the matching valid is high. A word transfers when both ready and valid are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the circuit under test |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| pat_count | input | CNT_W | Number of patterns in the run, sampled at start |
| chain_mode | input | 1 | 1 selects chain-only self-test, sampled at start |
| pat_valid | input | 1 | Pattern feed word valid |
| pat_data | input | CHAINS | Pattern word, one bit per chain |
| pat_ready | output | 1 | Pattern word taken this clock |
| exp_valid | input | 1 | Expected-response feed word valid |
| exp_data | input | CHAINS | Expected response word |
| exp_ready | output | 1 | Expected word taken this clock |
| scan_en | output | 1 | Chains shift this clock |
| hold_en | output | 1 | Chains keep their contents this clock |
| chain_in | output | CHAINS | Word driven into the chain heads |
| chain_out | input | CHAINS | Word read from the chain tails |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last response has been unloaded |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bound checker watches, on every clock, the relations between the test pins and the feeds. It checks that a capture clock never repeats, that shift and hold are exclusive, that feed transfers happen only on shift clocks with valid high, that the idle pins are frozen, and that fail is sticky and done implies idle.

The end-to-end behaviour can only be seen through the bench's runs against a model of the chains. That covers the overlap of unload and load, the ordering of response words, the exact run length for each mode, the zero fill during the last unload, and the detection of a corrupted word, including one in the final segment. The same holds for stall recovery, starts ignored mid-run, and the empty run.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_CAPT  = 2'd2
    } phase_e;

    // Control bundle handed from the sequencing FSM to datapath and pins.
    typedef struct packed {
        logic advance;   // chains shift this clock
        logic feed_pat;  // current segment loads pattern words
        logic feed_exp;  // current segment consumes expected words
        logic compare;   // current segment unloads a response
        logic chain;     // chain-only self-test run
    } step_s;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/scanseq_ctrl.sv
module scanseq_ctrl
    import scanseq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SCAN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] pat_count,
    input  logic             chain_mode,
    input  logic             pat_valid,
    input  logic             exp_valid,
    output phase_e           phase,
    output step_s            step,
    output logic             accept,
    output logic             done
);
    localparam int WC_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(SCAN_LEN - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] seg_q;
    logic [CNT_W-1:0] npat_q;
    logic             mode_q;
    logic [WC_W-1:0]  wc_q;
    logic             done_q;

    logic in_shift, need_pat, need_cmp, need_exp, adv;

    always_comb begin
        in_shift = (phase_q == PH_SHIFT);
        need_pat = in_shift && (seg_q < npat_q);
        need_cmp = in_shift && (seg_q != '0);
        need_exp = need_cmp && !mode_q;
        adv      = in_shift && (!need_pat || pat_valid) && (!need_exp || exp_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            seg_q   <= '0;
            npat_q  <= '0;
            mode_q  <= 1'b0;
            wc_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        done_q <= 1'b0;
                        npat_q <= pat_count;
                        mode_q <= chain_mode;
                        seg_q  <= '0;
                        wc_q   <= '0;
                        if (pat_count == '0) done_q  <= 1'b1;
                        else                 phase_q <= PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (adv) begin
                        if (wc_q == WC_LAST) begin
                            wc_q <= '0;
                            if (seg_q == npat_q) begin
                                phase_q <= PH_IDLE;
                                done_q  <= 1'b1;
                            end else if (mode_q) begin
                                seg_q <= seg_q + 1'b1;
                            end else begin
                                phase_q <= PH_CAPT;
                            end
                        end else begin
                            wc_q <= wc_q + 1'b1;
                        end
                    end
                end
                PH_CAPT: begin
                    seg_q   <= seg_q + 1'b1;
                    phase_q <= PH_SHIFT;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        phase         = phase_q;
        accept        = (phase_q == PH_IDLE) && start;
        done          = done_q;
        step.advance  = adv;
        step.feed_pat = need_pat;
        step.feed_exp = need_exp;
        step.compare  = need_cmp;
        step.chain    = mode_q;
    end

endmodule

// File: rtl/scanseq_resp.sv
module scanseq_resp
    import scanseq_pkg::*;
#(
    parameter int CHAINS   = 4,
    parameter int SCAN_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  step_s             step,
    input  logic [CHAINS-1:0] loaded,
    input  logic [CHAINS-1:0] exp_word,
    input  logic [CHAINS-1:0] unloaded,
    output logic              fail
);
    // Copy of the words put into the chains, used as reference in chain-only mode.
    logic [CHAINS-1:0] dly_q [SCAN_LEN];

    for (genvar i = 0; i < SCAN_LEN; i++) begin : g_dly
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)               dly_q[0] <= '0;
                else if (step.advance) dly_q[0] <= loaded;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)               dly_q[i] <= '0;
                else if (step.advance) dly_q[i] <= dly_q[i-1];
            end
        end
    end

    logic [CHAINS-1:0] ref_word;
    logic              mismatch;

    always_comb begin
        ref_word = step.chain ? dly_q[SCAN_LEN-1] : exp_word;
        mismatch = step.advance && step.compare && (unloaded != ref_word);
    end

    always_ff @(posedge clk) begin
        if (rst)           fail <= 1'b0;
        else if (clear)    fail <= 1'b0;
        else if (mismatch) fail <= 1'b1;
    end

endmodule

// File: rtl/scanseq_top.sv
module scanseq_top
    import scanseq_pkg::*;
#(
    parameter int CHAINS = 4,
    parameter int REGS   = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  pat_count,
    input  logic              chain_mode,
    input  logic              pat_valid,
    input  logic [CHAINS-1:0] pat_data,
    output logic              pat_ready,
    input  logic              exp_valid,
    input  logic [CHAINS-1:0] exp_data,
    output logic              exp_ready,
    output logic              scan_en,
    output logic              hold_en,
    output logic [CHAINS-1:0] chain_in,
    input  logic [CHAINS-1:0] chain_out,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int SCAN_LEN = ceil_div(REGS, CHAINS);

    phase_e phase;
    step_s  step;
    logic   accept;

    scanseq_ctrl #(.CNT_W(CNT_W), .SCAN_LEN(SCAN_LEN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pat_count  (pat_count),
        .chain_mode (chain_mode),
        .pat_valid  (pat_valid),
        .exp_valid  (exp_valid),
        .phase      (phase),
        .step       (step),
        .accept     (accept),
        .done       (done)
    );

    always_comb begin
        chain_in  = step.feed_pat ? pat_data : '0;
        scan_en   = step.advance;
        hold_en   = (phase == PH_IDLE) || ((phase == PH_SHIFT) && !step.advance);
        pat_ready = step.advance && step.feed_pat;
        exp_ready = step.advance && step.feed_exp;
        busy      = (phase != PH_IDLE);
    end

    scanseq_resp #(.CHAINS(CHAINS), .SCAN_LEN(SCAN_LEN)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .step     (step),
        .loaded   (chain_in),
        .exp_word (exp_data),
        .unloaded (chain_out),
        .fail     (fail)
    );

endmodule

// File: rtl/scanseq_sva.sv
module scanseq_sva (
    input logic clk,
    input logic rst,
    input logic start,
    input logic pat_valid,
    input logic exp_valid,
    input logic pat_ready,
    input logic exp_ready,
    input logic scan_en,
    input logic hold_en,
    input logic busy,
    input logic done,
    input logic fail
);
    assert_idle_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (hold_en && !scan_en && !pat_ready && !exp_ready));

    assert_single_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !scan_en && !hold_en) |=> (scan_en || hold_en));

    assert_pins_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(scan_en && hold_en));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && hold_en) |-> (!pat_ready && !exp_ready));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_xfer_on_shift_R11: assert property (@(posedge clk) disable iff (rst)
        (pat_ready || exp_ready) |-> scan_en);

    assert_ready_needs_valid_R11: assert property (@(posedge clk) disable iff (rst)
        (pat_ready |-> pat_valid) and (exp_ready |-> exp_valid));

endmodule

bind scanseq_top scanseq_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .pat_valid (pat_valid),
    .exp_valid (exp_valid),
    .pat_ready (pat_ready),
    .exp_ready (exp_ready),
    .scan_en   (scan_en),
    .hold_en   (hold_en),
    .busy      (busy),
    .done      (done),
    .fail      (fail)
);

// File: tb/tb_scanseq_top.sv
module tb_scanseq_top;
    localparam int CH  = 4;
    localparam int NR  = 10;
    localparam int CW  = 8;
    localparam int LEN = (NR + CH - 1) / CH;

    typedef struct packed {
        logic [7:0] n;
        logic       chain;
        logic       stall;
        logic       poke;
        logic [7:0] inj;   // 8'hFF: no corrupted word
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{8'd1, 1'b0, 1'b0, 1'b0, 8'hFF},
        '{8'd3, 1'b0, 1'b0, 1'b1, 8'hFF},
        '{8'd4, 1'b0, 1'b1, 1'b0, 8'hFF},
        '{8'd3, 1'b0, 1'b0, 1'b0, 8'd4},
        '{8'd2, 1'b1, 1'b0, 1'b0, 8'hFF},
        '{8'd3, 1'b1, 1'b1, 1'b0, 8'hFF},
        '{8'd3, 1'b1, 1'b0, 1'b0, 8'd7},
        '{8'd5, 1'b0, 1'b0, 1'b0, 8'd14}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] pat_count = '0;
    logic          chain_mode = 1'b0;
    logic          pat_valid = 1'b0;
    logic [CH-1:0] pat_data = '0;
    logic          pat_ready;
    logic          exp_valid = 1'b0;
    logic [CH-1:0] exp_data = '0;
    logic          exp_ready;
    logic          scan_en, hold_en, busy, done, fail;
    logic [CH-1:0] chain_in, chain_out;
    logic          flip = 1'b0;
    logic [CH-1:0] chain_q [LEN];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [CH-1:0] pat_word(input int row, input int k);
        return CH'((k * 3 + row * 5 + 1) % 16);
    endfunction

    function automatic logic [CH-1:0] capt_fn(input logic [CH-1:0] x);
        return {x[CH-2:0], x[CH-1]} ^ CH'(5);
    endfunction

    // Model of the circuit under test: LEN-deep chains with a functional capture.
    always_ff @(posedge clk) begin
        if (scan_en) begin
            chain_q[0] <= chain_in;
            for (int i = 1; i < LEN; i++) chain_q[i] <= chain_q[i-1];
        end else if (!hold_en) begin
            for (int i = 0; i < LEN; i++) chain_q[i] <= capt_fn(chain_q[i]);
        end
    end
    assign chain_out = chain_q[LEN-1] ^ {{(CH-1){1'b0}}, flip};

    scanseq_top #(.CHAINS(CH), .REGS(NR), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .start(start), .pat_count(pat_count),
        .chain_mode(chain_mode), .pat_valid(pat_valid), .pat_data(pat_data),
        .pat_ready(pat_ready), .exp_valid(exp_valid), .exp_data(exp_data),
        .exp_ready(exp_ready), .scan_en(scan_en), .hold_en(hold_en),
        .chain_in(chain_in), .chain_out(chain_out), .busy(busy),
        .done(done), .fail(fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_row(input row_t r, input int idx);
        int sh = 0, cyc = 0, busy_cyc = 0, capt = 0, words = 0, holds = 0;
        int early_exp = 0, nonzero_tail = 0;
        int n = int'(r.n);
        int c;
        bit efail;
        @(negedge clk);
        pat_count  = r.n;
        chain_mode = r.chain;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R6: accepted start clears a previous fail
        check(fail == 1'b0, "R6 fail cleared by start", int'(fail), 0);
        for (int guard = 0; guard < 1000; guard++) begin
            if (!busy) break;
            c = sh - LEN;
            start     = (r.poke && cyc == 5);   // R9 poke while busy
            pat_valid = !(r.stall && (cyc % 4) == 1);
            exp_valid = !(r.stall && (cyc % 4) == 3);
            pat_data  = pat_word(idx, sh);
            exp_data  = (c >= 0) ? capt_fn(pat_word(idx, c)) : '0;
            if (!r.chain && c == int'(r.inj)) exp_data = exp_data ^ CH'(1);
            flip = r.chain && (c == int'(r.inj));
            #1;
            busy_cyc++;
            if (exp_ready && sh < LEN) early_exp++;
            if (pat_ready && pat_valid) words++;
            if (!scan_en && !hold_en) capt++;
            if (hold_en) holds++;
            if (scan_en && sh >= n * LEN && chain_in != '0) nonzero_tail++;
            if (scan_en) sh++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        flip  = 1'b0;
        efail = (r.inj != 8'hFF) && (int'(r.inj) < n * LEN);
        check(done == 1'b1 && busy == 1'b0, "R5 done after run", int'(done), 1);
        check(words == n * LEN, "R2 pattern words taken", words, n * LEN);
        check(early_exp == 0, "R2 no expected word in first segment", early_exp, 0);
        check(nonzero_tail == 0, "R4 zero fill in unload segment", nonzero_tail, 0);
        check(fail == efail, r.chain ? "R7 chain compare" : "R6 response compare",
              int'(fail), int'(efail));
        if (r.chain) begin
            check(capt == 0, "R7 no capture clock", capt, 0);
            if (!r.stall)
                check(busy_cyc == (n + 1) * LEN, "R7 chain run length", busy_cyc, (n + 1) * LEN);
        end else begin
            check(capt == n, "R3 one capture per pattern", capt, n);
            if (!r.stall)
                check(busy_cyc == (n + 1) * LEN + n,
                      r.poke ? "R9 run length with start poke" : "R5 run length",
                      busy_cyc, (n + 1) * LEN + n);
        end
        if (r.stall) check(holds > 0, "R8 stall holds chains", holds, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fail, "R1 idle flags after reset", int'({busy, done, fail}), 0);
        check(!scan_en && hold_en && !pat_ready && !exp_ready, "R1 pins after reset",
              int'({scan_en, hold_en, pat_ready, exp_ready}), 4);

        for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

        // R10: empty run
        @(negedge clk);
        pat_count = '0; chain_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !busy, "R10 empty run finishes at once", int'({done, busy}), 2);
        check(!scan_en && hold_en, "R10 no shift on empty run", int'(scan_en), 0);

        // R11: idle ignores valid feeds
        pat_valid = 1'b1; exp_valid = 1'b1;
        #1;
        check(!pat_ready && !exp_ready, "R11 no transfer while idle",
              int'({pat_ready, exp_ready}), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule